// File: doc/BRIEF.md
# Host-Fed Pixel Stream Engine

This block takes pixels that a host processor writes one at a time into two register offsets and places them into a destination rectangle on screen. It produces a destination address and pixel word for each pixel, in raster order. A write to the start offset opens a transfer and carries its first pixel. Every later pixel of the same transfer arrives through the continuation offset. Each 32-bit write holds exactly one pixel, whatever the colour depth. No scaling is applied, so each source pixel fills exactly one destination pixel.

The rectangle corners, frame base address, screen stride (in pixels) and source colour mode are inputs. They must stay steady for the whole transfer. Address/pixel pairs leave the block for a write queue. When that queue reports full, the block raises a wait line, and the host holds its write until the line drops.

Top module: `hs_pixel_stream`

## Requirements
- R1: An accepted write to offset 0x0 while idle opens a transfer. One cycle later it emits the pixel for corner (x0,y0), and `busy` rises unless that corner is also (x1,y1).
- R2: While busy, each accepted write to offset 0x4 emits the next pixel one cycle after the write.
- R3: With `src_mode` = 0 (32 bits per pixel), the emitted pixel word equals the 32-bit write data unchanged. Each write gives exactly one output.
- R4: With `src_mode` = 1 (16 bits per pixel), bits 31:16 of the emitted word are zero and bits 15:0 equal the low half of the write data.
- R5: A write to offset 0x4 while idle produces no output and leaves `busy` low.
- R6: Pixels go left to right from x0 to x1. After x1 the position returns to x0 on the next row. Each address is `dst_base + ((y*stride + x) << ADDR_SHIFT)`.
- R7: `busy` falls in the cycle after the pixel at (x1,y1) is accepted. A one-pixel rectangle never raises `busy`.
- R8: While `out_full` is high, a pending write raises `host_wait` in the same cycle and is not taken. No output appears, and the position is kept until the write completes.
- R9: A write to offset 0x0 during an active transfer produces no output and does not move the position.
- R10: During reset, `out_valid` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | ADDR_W | Register offset of the write |
| wr_data | input | 32 | Write data, one pixel |
| host_wait | output | 1 | Stall for the pending host write |
| dst_x0 | input | COORD_W | Left column of the destination |
| dst_y0 | input | COORD_W | Top row of the destination |
| dst_x1 | input | COORD_W | Right column of the destination |
| dst_y1 | input | COORD_W | Bottom row of the destination |
| dst_base | input | DADDR_W | Frame base address |
| stride | input | COORD_W | Screen width in pixels |
| src_mode | input | 1 | 0: 32-bit pixels, 1: 16-bit pixels |
| out_full | input | 1 | Write queue cannot take a pair |
| out_valid | output | 1 | Address/pixel pair valid |
| out_addr | output | DADDR_W | Destination address |
| out_data | output | 32 | Pixel word |
| busy | output | 1 | Transfer in progress |

## Verification
Each accepted write gives its address/pixel pair, and its change to `busy`, exactly one cycle after the clock edge that takes it. `host_wait` follows `out_full` in the same cycle, with no register in between. The bench drives inputs just after the rising edge. A behavioural model updates its expectations on the same edge that the design registers on. The bench compares every output at the falling edge, so each result is checked in the one cycle it is due. Stalls, writes at the wrong offset and a one-pixel rectangle are placed so that a result that is early, late or spurious does not match the model.

// File: rtl/hs_pkg.sv
package hs_pkg;
   localparam int PIX_W = 32;
   localparam int HALF_W = PIX_W / 2;

   typedef enum logic {
      SRC_WIDE = 1'b0,
      SRC_HALF = 1'b1
   } src_depth_e;
endpackage

// File: rtl/hs_wr_decode.sv
module hs_wr_decode #(
   parameter int ADDR_W    = 4,
   parameter int START_OFS = 0,
   parameter int CONT_OFS  = 4
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic              out_full,
   input  logic              busy,
   output logic              take_start,
   output logic              take_cont,
   output logic              host_wait
);
   logic hit_start, hit_cont, can_take;

   assign hit_start  = (wr_addr == ADDR_W'(START_OFS));
   assign hit_cont   = (wr_addr == ADDR_W'(CONT_OFS));
   assign can_take   = wr_en & ~out_full;
   assign host_wait  = wr_en & out_full;
   assign take_start = can_take & hit_start & ~busy;
   assign take_cont  = can_take & hit_cont & busy;
endmodule

// File: rtl/hs_cursor.sv
module hs_cursor #(
   parameter int COORD_W = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               take_start,
   input  logic               take_cont,
   input  logic [COORD_W-1:0] x0,
   input  logic [COORD_W-1:0] y0,
   input  logic [COORD_W-1:0] x1,
   input  logic [COORD_W-1:0] y1,
   output logic [COORD_W-1:0] pix_x,
   output logic [COORD_W-1:0] pix_y,
   output logic               fire,
   output logic               busy
);
   logic [COORD_W-1:0] nxt_x, nxt_y;
   logic at_row_end, at_last;

   assign fire       = take_start | take_cont;
   assign pix_x      = take_start ? x0 : nxt_x;
   assign pix_y      = take_start ? y0 : nxt_y;
   assign at_row_end = (pix_x == x1);
   assign at_last    = at_row_end & (pix_y == y1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         nxt_x <= '0;
         nxt_y <= '0;
      end else if (fire) begin
         busy <= ~at_last;
         if (at_row_end) begin
            nxt_x <= x0;
            nxt_y <= pix_y + 1'b1;
         end else begin
            nxt_x <= pix_x + 1'b1;
            nxt_y <= pix_y;
         end
      end
   end
endmodule

// File: rtl/hs_emit.sv
module hs_emit
   import hs_pkg::*;
#(
   parameter int COORD_W    = 12,
   parameter int DADDR_W    = 32,
   parameter int ADDR_SHIFT = 2,
   parameter bit SUPPORT_16 = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fire,
   input  logic [COORD_W-1:0] pix_x,
   input  logic [COORD_W-1:0] pix_y,
   input  logic [DADDR_W-1:0] base,
   input  logic [COORD_W-1:0] stride,
   input  logic               mode,
   input  logic [PIX_W-1:0]   data,
   output logic               out_valid,
   output logic [DADDR_W-1:0] out_addr,
   output logic [PIX_W-1:0]   out_data
);
   localparam int ROW_W = 2 * COORD_W;
   localparam int OFF_W = ROW_W + 1;

   logic [ROW_W-1:0]   row_ofs;
   logic [OFF_W-1:0]   pix_ofs;
   logic [DADDR_W-1:0] addr_n;
   logic [PIX_W-1:0]   data_n;

   assign row_ofs = ROW_W'({{COORD_W{1'b0}}, pix_y} * {{COORD_W{1'b0}}, stride});
   assign pix_ofs = {1'b0, row_ofs} + {{(COORD_W+1){1'b0}}, pix_x};
   assign addr_n  = base + (DADDR_W'(pix_ofs) << ADDR_SHIFT);

   generate
      if (SUPPORT_16) begin : g_half
         assign data_n = (src_depth_e'(mode) == SRC_HALF) ?
                         {{HALF_W{1'b0}}, data[HALF_W-1:0]} : data;
      end else begin : g_wide
         logic unused_mode;
         assign unused_mode = mode;
         assign data_n = data;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_addr  <= '0;
         out_data  <= '0;
      end else begin
         out_valid <= fire;
         if (fire) begin
            out_addr <= addr_n;
            out_data <= data_n;
         end
      end
   end
endmodule

// File: rtl/hs_pixel_stream.sv
module hs_pixel_stream #(
   parameter int ADDR_W     = 4,
   parameter int START_OFS  = 0,
   parameter int CONT_OFS   = 4,
   parameter int COORD_W    = 12,
   parameter int DADDR_W    = 32,
   parameter int ADDR_SHIFT = 2,
   parameter bit SUPPORT_16 = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [31:0]        wr_data,
   output logic               host_wait,
   input  logic [COORD_W-1:0] dst_x0,
   input  logic [COORD_W-1:0] dst_y0,
   input  logic [COORD_W-1:0] dst_x1,
   input  logic [COORD_W-1:0] dst_y1,
   input  logic [DADDR_W-1:0] dst_base,
   input  logic [COORD_W-1:0] stride,
   input  logic               src_mode,
   input  logic               out_full,
   output logic               out_valid,
   output logic [DADDR_W-1:0] out_addr,
   output logic [31:0]        out_data,
   output logic               busy
);
   generate
      if (COORD_W < 2 || COORD_W > 16) begin : g_bad_coord
         $error("COORD_W out of range");
      end
      if (DADDR_W < 2 * COORD_W + 1 + ADDR_SHIFT) begin : g_bad_addr
         $error("DADDR_W too narrow for the pixel offset");
      end
      if (START_OFS == CONT_OFS || START_OFS >= (1 << ADDR_W) || CONT_OFS >= (1 << ADDR_W)) begin : g_bad_ofs
         $error("register offsets invalid");
      end
   endgenerate

   logic take_start, take_cont, fire;
   logic [COORD_W-1:0] pix_x, pix_y;

   hs_wr_decode #(
      .ADDR_W(ADDR_W), .START_OFS(START_OFS), .CONT_OFS(CONT_OFS)
   ) u_dec (
      .wr_en(wr_en), .wr_addr(wr_addr), .out_full(out_full), .busy(busy),
      .take_start(take_start), .take_cont(take_cont), .host_wait(host_wait)
   );

   hs_cursor #(.COORD_W(COORD_W)) u_cur (
      .clk(clk), .rst_n(rst_n), .take_start(take_start), .take_cont(take_cont),
      .x0(dst_x0), .y0(dst_y0), .x1(dst_x1), .y1(dst_y1),
      .pix_x(pix_x), .pix_y(pix_y), .fire(fire), .busy(busy)
   );

   hs_emit #(
      .COORD_W(COORD_W), .DADDR_W(DADDR_W), .ADDR_SHIFT(ADDR_SHIFT), .SUPPORT_16(SUPPORT_16)
   ) u_emit (
      .clk(clk), .rst_n(rst_n), .fire(fire), .pix_x(pix_x), .pix_y(pix_y),
      .base(dst_base), .stride(stride), .mode(src_mode), .data(wr_data),
      .out_valid(out_valid), .out_addr(out_addr), .out_data(out_data)
   );
endmodule

// File: rtl/hs_stream_chk.sv
module hs_stream_chk #(
   parameter int ADDR_W     = 4,
   parameter int START_OFS  = 0,
   parameter int CONT_OFS   = 4,
   parameter int COORD_W    = 12,
   parameter int DADDR_W    = 32,
   parameter int ADDR_SHIFT = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic               wr_en,
   input logic [ADDR_W-1:0]  wr_addr,
   input logic [31:0]        wr_data,
   input logic [COORD_W-1:0] dst_x0,
   input logic [COORD_W-1:0] dst_y0,
   input logic [DADDR_W-1:0] dst_base,
   input logic [COORD_W-1:0] stride,
   input logic               src_mode,
   input logic               out_full,
   input logic               out_valid,
   input logic [DADDR_W-1:0] out_addr,
   input logic [31:0]        out_data,
   input logic               busy
);
   logic is_start, is_cont, free;
   logic [DADDR_W-1:0] corner_addr;

   assign is_start    = wr_en && (wr_addr == ADDR_W'(START_OFS));
   assign is_cont     = wr_en && (wr_addr == ADDR_W'(CONT_OFS));
   assign free        = !out_full;
   assign corner_addr = dst_base +
      (DADDR_W'(DADDR_W'(dst_y0) * DADDR_W'(stride) + DADDR_W'(dst_x0)) << ADDR_SHIFT);

   AST_START_CORNER: assert property (@(posedge clk) disable iff (!rst_n)
      (is_start && free && !busy) |=> (out_valid && out_addr == $past(corner_addr))); // R1
   AST_CONT_EMITS: assert property (@(posedge clk) disable iff (!rst_n)
      (is_cont && free && busy) |=> out_valid); // R2
   AST_WIDE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && free && !busy && is_start && !src_mode) |=> (out_data == $past(wr_data))); // R3
   AST_HALF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ((is_start || is_cont) && src_mode) |=> (!out_valid || out_data[31:16] == 16'h0)); // R4
   AST_IDLE_CONT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (is_cont && !busy) |=> (!out_valid && !busy)); // R5
   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && out_full) |=> (!out_valid && busy == $past(busy))); // R8
   AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (is_start && busy) |=> !out_valid); // R9
endmodule

bind hs_pixel_stream hs_stream_chk #(
   .ADDR_W(ADDR_W), .START_OFS(START_OFS), .CONT_OFS(CONT_OFS),
   .COORD_W(COORD_W), .DADDR_W(DADDR_W), .ADDR_SHIFT(ADDR_SHIFT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
   .dst_x0(dst_x0), .dst_y0(dst_y0), .dst_base(dst_base), .stride(stride),
   .src_mode(src_mode), .out_full(out_full), .out_valid(out_valid),
   .out_addr(out_addr), .out_data(out_data), .busy(busy)
);

// File: tb/hs_pixel_stream_test.sv
module hs_pixel_stream_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        host_wait;
   logic [11:0] dst_x0 = '0, dst_y0 = '0, dst_x1 = '0, dst_y1 = '0, stride = 12'd16;
   logic [31:0] dst_base = '0;
   logic        src_mode = 1'b0;
   logic        out_full = 1'b0;
   logic        out_valid, busy;
   logic [31:0] out_addr, out_data;

   int n_chk = 0, n_fail = 0;
   bit started = 0, done = 0;
   string phase = "R10";

   // behavioural reference
   bit m_busy = 0, m_valid = 0;
   int m_x = 0, m_y = 0;
   logic [31:0] m_addr = '0, m_data = '0;

   always #10 clk = ~clk;

   hs_pixel_stream uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .host_wait(host_wait), .dst_x0(dst_x0), .dst_y0(dst_y0), .dst_x1(dst_x1),
      .dst_y1(dst_y1), .dst_base(dst_base), .stride(stride), .src_mode(src_mode),
      .out_full(out_full), .out_valid(out_valid), .out_addr(out_addr),
      .out_data(out_data), .busy(busy)
   );

   always @(posedge clk) begin
      started <= 1;
      if (!rst_n) begin
         m_busy = 0; m_valid = 0;
      end else begin
         bit take;
         int px, py;
         take = 0;
         if (wr_en && !out_full) begin
            if (wr_addr == 4'h0 && !m_busy) begin take = 1; px = dst_x0; py = dst_y0; end
            else if (wr_addr == 4'h4 && m_busy) begin take = 1; px = m_x; py = m_y; end
         end
         m_valid = take;
         if (take) begin
            m_addr = dst_base + ((py * stride + px) << 2);
            m_data = src_mode ? {16'h0, wr_data[15:0]} : wr_data;
            m_busy = !(px == dst_x1 && py == dst_y1);
            if (px == dst_x1) begin m_x = dst_x0; m_y = py + 1; end
            else begin m_x = px + 1; m_y = py; end
         end
      end
   end

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) if (started && !done) begin
      check({phase, " valid"}, 32'(out_valid), 32'(m_valid));
      check("R7 busy", 32'(busy), 32'(m_busy));
      check("R8 host_wait", 32'(host_wait), 32'(wr_en && out_full));
      if (m_valid) begin
         check("R6 addr", out_addr, m_addr);
         check(src_mode ? "R4 data" : "R3 data", out_data, m_data);
      end
   end

   task automatic hwrite(logic [3:0] a, logic [31:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk);
      while (host_wait) @(posedge clk);
      #2 wr_en = 1'b0;
   endtask

   task automatic rect(int x0, int y0, int x1, int y1, int s, logic [31:0] b, logic m);
      dst_x0 = 12'(x0); dst_y0 = 12'(y0); dst_x1 = 12'(x1); dst_y1 = 12'(y1);
      stride = 12'(s); dst_base = b; src_mode = m;
   endtask

   task automatic finish_run();
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      #(20 * 100000);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      @(posedge clk); #2;

      phase = "R5";
      hwrite(4'h4, 32'hDEAD_BEEF);
      @(posedge clk); #2;

      phase = "R1 R2";
      rect(2, 1, 4, 2, 16, 32'h0000_1000, 1'b0);
      hwrite(4'h0, 32'hA000_0000);
      hwrite(4'h4, 32'hA000_0001);
      phase = "R9";
      hwrite(4'h0, 32'hBAD0_0000);
      phase = "R8";
      out_full = 1'b1;
      fork begin repeat (3) @(posedge clk); #2 out_full = 1'b0; end join_none
      hwrite(4'h4, 32'hA000_0002);
      phase = "R2 R6";
      for (int i = 3; i < 6; i++) hwrite(4'h4, 32'hA000_0000 + i);
      @(posedge clk); #2;
      phase = "R5";
      hwrite(4'h4, 32'h1234_5678);
      @(posedge clk); #2;

      phase = "R4";
      rect(0, 0, 1, 1, 8, 32'h0000_0200, 1'b1);
      hwrite(4'h0, 32'hFFFF_1111);
      for (int i = 0; i < 3; i++) hwrite(4'h4, 32'hCAFE_2220 + i);
      @(posedge clk); #2;

      phase = "R7";
      rect(5, 5, 5, 5, 20, 32'h0000_4000, 1'b0);
      hwrite(4'h0, 32'h5555_AAAA);
      phase = "R5";
      hwrite(4'h4, 32'h0BAD_0BAD);
      repeat (3) @(posedge clk);
      #2 finish_run();
   end
endmodule